// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block sends one character at a time on a single serial output line. It uses a non-return-to-zero asynchronous frame: the line rests high, a low start bit opens the frame, the data bits follow with the least significant bit first, and a high stop bit closes the frame. A mode input selects a character of eight or nine data bits. The bit timing comes from an external rate generator. That generator supplies a one-cycle `bit_tick` strobe at the transmit bit rate, and every bit on the line, start and stop included, lasts exactly one tick period.

Characters enter through a valid/ready handshake. The mode input and a break request are taken together with the character. A break frame holds the line low for one whole frame time: 10 bit periods in 8-bit mode or 11 in 9-bit mode. After that the line returns high. `busy` shows that a frame is pending or in flight. `done` pulses for one cycle when a frame's last bit period ends. A new character can be accepted in the same cycle that the stop bit ends, so frames can run back to back with no gap.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `tx_line` is 1, `busy` is 0 and `in_ready` is 1.
- R2: After a character is accepted, the first clock edge that samples `bit_tick` high drives `tx_line` to 0 (the start bit) for one tick period.
- R3: Data bits follow the start bit, bit 0 first, each for exactly one tick period; `tx_line` changes only at edges that sample `bit_tick` high.
- R4: The last bit period of a normal frame is a stop bit at 1. The line stays 1 afterwards unless another frame starts.
- R5: `nine_bit_mode` and `in_break` are sampled at acceptance. With mode 1 the frame carries `in_data[8:0]` (11 bit periods). With mode 0 it carries `in_data[7:0]` (10 bit periods), and `in_data[8]` has no effect on the line.
- R6: A character accepted with `in_break`=1 holds `tx_line` at 0 for 10 tick periods (mode 0) or 11 (mode 1), then returns it to 1.
- R7: `in_ready` is 0 from acceptance until the cycle in which the edge ending the last bit period is about to occur; it is 1 in that cycle. A character accepted there starts its start bit at that same edge, with no idle gap.
- R8: `busy` is 1 from the edge after acceptance until the frame ends. `done` is 1 for exactly the one cycle after the edge that ends a frame.
- R9: `in_valid` raised while a frame is in flight (`in_ready`=0) does not alter the frame on the line, and the held character is accepted only when `in_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per transmit bit period |
| nine_bit_mode | input | 1 | 1 selects nine data bits, 0 selects eight |
| in_valid | input | 1 | Character offered |
| in_data | input | 9 | Character, bit 0 sent first |
| in_break | input | 1 | Send a full-frame break instead of the character |
| in_ready | output | 1 | Character can be taken this cycle |
| tx_line | output | 1 | Serial output line, idle high |
| busy | output | 1 | Frame pending or being sent |
| done | output | 1 | One-cycle pulse after a frame ends |

## Verification
The bench builds the block with its default parameter `NINE_BIT_EN`=1, so the nine-bit data path, the 9-bit register and the 11-period frame are all present. In that build the mode input really switches between 10- and 11-period frames and between both break lengths. The bench drives `bit_tick` once every four clocks. That makes a full frame short enough to walk every bit period of every vector, and it leaves idle cycles between ticks in which line stability and the readiness window can be observed. The back-to-back case changes the mode input while a frame is in flight, which shows the mode is latched at acceptance.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_WAIT = 2'd1,
      TX_SEND = 2'd2
   } tx_state_e;

   localparam int FRAME8_BITS = 10;
   localparam int FRAME9_BITS = 11;

endpackage

// File: rtl/serial_tx_seq.sv
module serial_tx_seq
   import serial_tx_pkg::*;
#(
   parameter int NINE_BIT_EN = 1,
   parameter int CNT_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             in_valid,
   input  logic             nine_sel,
   input  logic             brk_sel,
   output logic             accept,
   output logic             start_frame,
   output logic             advance,
   output logic             frame_end,
   output logic             next_is_stop,
   output logic             sending,
   output logic             brk_q,
   output logic             in_ready,
   output logic             busy,
   output logic             done
);

   localparam logic [CNT_W-1:0] LAST8 = CNT_W'(FRAME8_BITS - 1);
   localparam logic [CNT_W-1:0] LAST9 = CNT_W'(FRAME9_BITS - 1);

   tx_state_e        state_q;
   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] last_idx;
   logic             mode_q;
   logic             at_last;

   generate
      if (NINE_BIT_EN != 0) begin : g_mode_sel
         always_ff @(posedge clk) begin
            if (!rst_n)      mode_q <= 1'b0;
            else if (accept) mode_q <= nine_sel;
         end
      end else begin : g_mode_fixed
         always_ff @(posedge clk) begin
            mode_q <= 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      brk_q <= 1'b0;
      else if (accept) brk_q <= brk_sel;
   end

   assign last_idx     = mode_q ? LAST9 : LAST8;
   assign sending      = (state_q == TX_SEND);
   assign at_last      = sending && (idx_q == last_idx);
   assign frame_end    = at_last && bit_tick;
   assign in_ready     = (state_q == TX_IDLE) || frame_end;
   assign accept       = in_valid && in_ready;
   assign start_frame  = ((state_q == TX_WAIT) && bit_tick) || (frame_end && accept);
   assign advance      = sending && bit_tick && !at_last;
   assign next_is_stop = (idx_q == (last_idx - 1'b1));
   assign busy         = (state_q != TX_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         idx_q   <= '0;
      end else begin
         unique case (state_q)
            TX_IDLE: begin
               if (accept) state_q <= TX_WAIT;
            end
            TX_WAIT: begin
               if (bit_tick) begin
                  state_q <= TX_SEND;
                  idx_q   <= '0;
               end
            end
            TX_SEND: begin
               if (frame_end) begin
                  idx_q   <= '0;
                  state_q <= accept ? TX_SEND : TX_IDLE;
               end else if (bit_tick) begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: state_q <= TX_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) done <= 1'b0;
      else        done <= frame_end;
   end

   p_ready_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && busy) |-> bit_tick);

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_busy_end_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

// File: rtl/serial_tx_shreg.sv
module serial_tx_shreg #(
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] load_data,
   output logic              lsb
);

   logic [DATA_W-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     sh_q <= '0;
      else if (load)  sh_q <= load_data;
      else if (shift) sh_q <= {1'b0, sh_q[DATA_W-1:1]};
   end

   assign lsb = sh_q[0];

endmodule

// File: rtl/serial_tx_line.sv
module serial_tx_line (
   input  logic clk,
   input  logic rst_n,
   input  logic start_frame,
   input  logic advance,
   input  logic frame_end,
   input  logic next_is_stop,
   input  logic brk,
   input  logic sending,
   input  logic data_bit,
   output logic line
);

   always_ff @(posedge clk) begin
      if (!rst_n)           line <= 1'b1;
      else if (start_frame) line <= 1'b0;
      else if (advance)     line <= brk ? 1'b0 : (next_is_stop ? 1'b1 : data_bit);
      else if (frame_end)   line <= 1'b1;
   end

   p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sending && brk) |-> !line);

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
   import serial_tx_pkg::*;
#(
   parameter int NINE_BIT_EN = 1,
   localparam int DATA_W     = (NINE_BIT_EN != 0) ? 9 : 8,
   localparam int CNT_W      = $clog2(FRAME9_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              nine_bit_mode,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_break,
   output logic              in_ready,
   output logic              tx_line,
   output logic              busy,
   output logic              done
);

   generate
      if (NINE_BIT_EN != 0 && NINE_BIT_EN != 1) begin : g_bad_param
         $error("serial_frame_tx: NINE_BIT_EN must be 0 or 1");
      end
   endgenerate

   logic accept, start_frame, advance, frame_end, next_is_stop;
   logic sending, brk_q, data_bit;

   serial_tx_seq #(
      .NINE_BIT_EN (NINE_BIT_EN),
      .CNT_W       (CNT_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_tick     (bit_tick),
      .in_valid     (in_valid),
      .nine_sel     (nine_bit_mode),
      .brk_sel      (in_break),
      .accept       (accept),
      .start_frame  (start_frame),
      .advance      (advance),
      .frame_end    (frame_end),
      .next_is_stop (next_is_stop),
      .sending      (sending),
      .brk_q        (brk_q),
      .in_ready     (in_ready),
      .busy         (busy),
      .done         (done)
   );

   serial_tx_shreg #(
      .DATA_W (DATA_W)
   ) u_shreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .shift     (advance),
      .load_data (in_data),
      .lsb       (data_bit)
   );

   serial_tx_line u_line (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_frame  (start_frame),
      .advance      (advance),
      .frame_end    (frame_end),
      .next_is_stop (next_is_stop),
      .brk          (brk_q),
      .sending      (sending),
      .data_bit     (data_bit),
      .line         (tx_line)
   );

   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx_line);

   p_line_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(tx_line));

endmodule

// File: tb/serial_frame_tx_tb.sv
`timescale 1ns/1ps
module serial_frame_tx_tb;

   localparam int TICK_DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       nine_bit_mode = 1'b0;
   logic       in_valid = 1'b0;
   logic [8:0] in_data = '0;
   logic       in_break = 1'b0;
   logic       in_ready, tx_line, busy, done;

   int errors = 0;
   int checks = 0;
   int tick_cnt = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   always @(posedge clk) begin
      tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
      bit_tick <= (tick_cnt == TICK_DIV - 2);
   end

   serial_frame_tx u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .bit_tick      (bit_tick),
      .nine_bit_mode (nine_bit_mode),
      .in_valid      (in_valid),
      .in_data       (in_data),
      .in_break      (in_break),
      .in_ready      (in_ready),
      .tx_line       (tx_line),
      .busy          (busy),
      .done          (done)
   );

   // vector: {mode, break, data[8:0]}
   localparam logic [10:0] VEC [6] = '{
      {1'b0, 1'b0, 9'h0A5},
      {1'b1, 1'b0, 9'h1A5},
      {1'b1, 1'b0, 9'h0FF},
      {1'b0, 1'b0, 9'h155},
      {1'b0, 1'b1, 9'h0FF},
      {1'b1, 1'b1, 9'h1FF}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int frame_len(input bit mode);
      return mode ? 11 : 10;
   endfunction

   function automatic bit exp_bit(input bit mode, input bit brk, input logic [8:0] d, input int i);
      if (brk) return 1'b0;
      if (i == 0) return 1'b0;
      if (i == frame_len(mode) - 1) return 1'b1;
      return d[i-1];
   endfunction

   function automatic string bit_req(input bit mode, input bit brk, input int i);
      if (brk) return "R6 break low";
      if (i == 0) return "R2 start bit";
      if (i == frame_len(mode) - 1) return "R4 stop bit";
      if (mode && i == 9) return "R5 ninth bit";
      return "R3 data bit";
   endfunction

   task automatic wait_tick_edge();
      do @(negedge clk); while (!bit_tick);
      @(posedge clk);
      #2;
   endtask

   task automatic send(input bit mode, input bit brk, input logic [8:0] d);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; nine_bit_mode = mode; in_break = brk;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      chk(busy === 1'b1, "R8 busy after accept", busy, 1);
      chk(in_ready === 1'b0, "R7 ready low after accept", in_ready, 0);
      chk(tx_line === 1'b1, "R2 line high until tick", tx_line, 1);
   endtask

   task automatic check_bits(input bit mode, input bit brk, input logic [8:0] d, input int from);
      for (int i = from; i < frame_len(mode); i++) begin
         wait_tick_edge();
         chk(tx_line === exp_bit(mode, brk, d, i), bit_req(mode, brk, i),
             tx_line, exp_bit(mode, brk, d, i));
      end
   endtask

   task automatic check_end();
      wait_tick_edge();
      chk(tx_line === 1'b1, "R4 line high after frame", tx_line, 1);
      chk(done === 1'b1, "R8 done after frame", done, 1);
      chk(busy === 1'b0, "R8 busy low after frame", busy, 0);
      @(posedge clk); #2;
      chk(done === 1'b0, "R8 done single cycle", done, 0);
      chk(in_ready === 1'b1, "R1 ready when idle", in_ready, 1);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [10:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #2;
      // R1 reset state
      chk(tx_line === 1'b1, "R1 line after reset", tx_line, 1);
      chk(busy === 1'b0, "R1 busy after reset", busy, 0);
      chk(in_ready === 1'b1, "R1 ready after reset", in_ready, 1);
      chk(done === 1'b0, "R1 done after reset", done, 0);
      repeat (3 * TICK_DIV) @(posedge clk);
      #2;
      chk(tx_line === 1'b1, "R1 idle line stays high", tx_line, 1);

      // table walk: R2..R6
      for (int k = 0; k < 6; k++) begin
         v = VEC[k];
         send(v[10], v[9], v[8:0]);
         check_bits(v[10], v[9], v[8:0], 0);
         check_end();
      end

      // back-to-back with held request during a frame: R7, R9, R5 latch
      send(1'b0, 1'b0, 9'h0C3);
      check_bits(1'b0, 1'b0, 9'h0C3, 0);
      // the stop bit above was checked; restart a new frame to test holding
      check_end();
      send(1'b0, 1'b0, 9'h1C3);
      check_bits(1'b0, 1'b0, 9'h1C3, 0);
      @(negedge clk);
      in_valid = 1'b1; in_data = 9'h12D; nine_bit_mode = 1'b1; in_break = 1'b0;
      #1;
      chk(in_ready === 1'b0, "R9 ready low during stop bit", in_ready, 0);
      wait_tick_edge();
      in_valid = 1'b0;
      chk(tx_line === 1'b0, "R7 back-to-back start bit", tx_line, 0);
      chk(busy === 1'b1, "R7 busy stays high", busy, 1);
      chk(done === 1'b1, "R8 done at back-to-back end", done, 1);
      check_bits(1'b1, 1'b0, 9'h12D, 1);
      check_end();

      // R9: request raised early is held off until the frame ends
      send(1'b0, 1'b0, 9'h03C);
      wait_tick_edge();
      chk(tx_line === 1'b0, "R2 start bit", tx_line, 0);
      @(negedge clk);
      in_valid = 1'b1; in_data = 9'h1FF; nine_bit_mode = 1'b1; in_break = 1'b1;
      #1;
      chk(in_ready === 1'b0, "R9 ready low mid frame", in_ready, 0);
      for (int i = 1; i < 10; i++) begin
         wait_tick_edge();
         chk(tx_line === exp_bit(1'b0, 1'b0, 9'h03C, i), "R9 frame unaltered",
             tx_line, exp_bit(1'b0, 1'b0, 9'h03C, i));
      end
      wait_tick_edge();
      in_valid = 1'b0;
      chk(tx_line === 1'b0, "R7 held request starts at end edge", tx_line, 0);
      check_bits(1'b1, 1'b1, 9'h1FF, 1);
      check_end();

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule